// File: doc/BRIEF.md
# Function-Unit Result Table with Writer History

This block tracks, for every architectural register, which function unit (FU) was most recently issued to write that register. Each register also keeps a short stack of earlier writers whose results have been overwritten before they reached the register file. Those superseded ("nameless") writers must hold their results back. The same stack lets the table fall back to an older writer when an exception cancels newer ones.

The issue stage presents a register number and a one-hot FU code. The table pushes that FU on top of the register's stack, or refuses the issue when the stack is full. When the oldest writer of a register retires, the retire port names it, and it is removed from the bottom of the stack. An exception presents a mask of cancelled FUs. In one cycle, every stack in the table drops those units and closes up the gaps. The table publishes the current writer of every register in one-hot form, a per-register valid bit, and a per-FU flag that is set while that unit sits anywhere below the top of some stack. The commit logic uses that flag to stop the unit from writing the register file.

Top module: `fu_result_table`

## Requirements
- R1: After reset every register reports no writer (valid 0, writer code all zero), no FU is commit-blocked, and issue is ready.
- R2: An accepted issue of one-hot FU code f to register r makes f the writer reported for r from the next cycle, with valid 1. No other register's report changes because of it.
- R3: A register's reported writer code is one-hot whenever its valid bit is 1 and all zero whenever it is 0. FU k is bit k of the code.
- R4: Each issue to a register that already has writers pushes the new FU on top. Every FU that lies below the top of any register's stack has its commit-block bit set; an FU that is only ever on top has it clear.
- R5: Each register holds at most 4 writers. While the addressed register is full, `iss_ready` is 0 and an issue to it has no effect.
- R6: A retire whose FU code equals the bottom (oldest) entry of a register removes that entry, and the register's valid bit drops when its stack becomes empty. A retire code that matches no bottom entry changes nothing.
- R7: A rollback removes, in one cycle and from every register, each entry whose FU is set in the cancel mask. The survivors keep their order, and the reported writer becomes the newest survivor, or valid 0 if none is left.
- R8: In a cycle with rollback asserted, issue and retire are ignored.
- R9: Issue and retire in the same cycle both take effect. Retire removes the bottom entry first. Issue readiness is judged on the stack contents before that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid | input | 1 | Issue request |
| iss_reg | input | $clog2(NREG) | Destination register of the issue |
| iss_fu | input | NFU | One-hot FU being issued |
| iss_ready | output | 1 | Addressed register has room for another writer |
| ret_valid | input | 1 | Retire request |
| ret_fu | input | NFU | One-hot FU leaving the bottom of its register's stack |
| rb_valid | input | 1 | Exception rollback |
| rb_mask | input | NFU | Cancelled FUs, one bit per unit |
| cur_fu | output | NREG*NFU | Current writer per register, register r at bits r*NFU and up |
| cur_vld | output | NREG | A writer is pending for each register |
| commit_block | output | NFU | FU is superseded somewhere and must not commit |

## Verification
A stack entry that is lost or duplicated shows up at once on `cur_fu` or `commit_block` in the cycle after the command. A fault can also stay hidden until a retire or rollback later exposes the entry below it, so the bench compares every register's report and the full block vector after every cycle against an independent model. A wrong fill count shows up either as an early or late drop of `iss_ready`, or as a reported writer taken from the wrong depth. Rollback masks are swept exhaustively over a filled table, so a compaction fault is exposed within one cycle.

// File: rtl/frt_pkg.sv
package frt_pkg;
  localparam int DEF_NREG  = 8;
  localparam int DEF_NFU   = 4;
  localparam int DEF_DEPTH = 4;
endpackage

// File: rtl/frt_reg_stack.sv
module frt_reg_stack #(
  parameter int NFU   = 4,
  parameter int DEPTH = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           push_en,
  input  logic [NFU-1:0] push_fu,
  input  logic           pop_en,
  input  logic [NFU-1:0] pop_fu,
  input  logic           rb_en,
  input  logic [NFU-1:0] rb_mask,
  output logic [NFU-1:0] top_fu,
  output logic           top_vld,
  output logic           full,
  output logic [NFU-1:0] older_fu
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [NFU-1:0] ent_q [DEPTH];
  logic [NFU-1:0] ent_d [DEPTH];
  logic [CW-1:0]  cnt_q, cnt_d;
  logic [DEPTH-1:0] keep;
  int             rank [DEPTH];
  logic [CW-1:0]  base;
  logic           pop_hit;

  assign full    = (cnt_q == CW'(DEPTH));
  assign top_vld = (cnt_q != '0);
  assign pop_hit = pop_en && top_vld && (ent_q[0] == pop_fu);

  // survivors of a rollback and their compacted positions
  always_comb begin
    int acc;
    acc = 0;
    for (int i = 0; i < DEPTH; i++) begin
      keep[i] = (CW'(i) < cnt_q) && ((ent_q[i] & rb_mask) == '0);
      rank[i] = acc;
      if (keep[i]) acc = acc + 1;
    end
  end

  always_comb begin
    for (int i = 0; i < DEPTH; i++) ent_d[i] = ent_q[i];
    cnt_d = cnt_q;
    base  = cnt_q;
    if (rb_en) begin
      cnt_d = '0;
      for (int j = 0; j < DEPTH; j++) begin
        ent_d[j] = '0;
        for (int i = 0; i < DEPTH; i++)
          if (keep[i] && rank[i] == j) ent_d[j] = ent_q[i];
      end
      for (int i = 0; i < DEPTH; i++)
        if (keep[i]) cnt_d = cnt_d + 1'b1;
    end else begin
      if (pop_hit) begin
        for (int i = 0; i < DEPTH - 1; i++) ent_d[i] = ent_q[i+1];
        ent_d[DEPTH-1] = '0;
        base = cnt_q - 1'b1;
      end
      cnt_d = base;
      if (push_en && !full) begin
        for (int j = 0; j < DEPTH; j++)
          if (CW'(j) == base) ent_d[j] = push_fu;
        cnt_d = base + 1'b1;
      end
    end
  end

  always_comb begin
    top_fu   = '0;
    older_fu = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (CW'(i + 1) == cnt_q) top_fu = ent_q[i];
      if (CW'(i + 1) <  cnt_q) older_fu = older_fu | ent_q[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) ent_q[i] <= '0;
    end else begin
      cnt_q <= cnt_d;
      for (int i = 0; i < DEPTH; i++) ent_q[i] <= ent_d[i];
    end
  end
endmodule

// File: rtl/frt_hold_or.sv
module frt_hold_or #(
  parameter int NREG = 8,
  parameter int NFU  = 4
) (
  input  logic [NREG*NFU-1:0] older_flat,
  output logic [NFU-1:0]      hold
);
  always_comb begin
    hold = '0;
    for (int r = 0; r < NREG; r++) hold = hold | older_flat[r*NFU +: NFU];
  end
endmodule

// File: rtl/fu_result_table.sv
module fu_result_table #(
  parameter int NREG  = frt_pkg::DEF_NREG,
  parameter int NFU   = frt_pkg::DEF_NFU,
  parameter int DEPTH = frt_pkg::DEF_DEPTH,
  localparam int RW   = $clog2(NREG)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                iss_valid,
  input  logic [RW-1:0]       iss_reg,
  input  logic [NFU-1:0]      iss_fu,
  output logic                iss_ready,
  input  logic                ret_valid,
  input  logic [NFU-1:0]      ret_fu,
  input  logic                rb_valid,
  input  logic [NFU-1:0]      rb_mask,
  output logic [NREG*NFU-1:0] cur_fu,
  output logic [NREG-1:0]     cur_vld,
  output logic [NFU-1:0]      commit_block
);
  logic [NREG-1:0]     full_vec;
  logic [NREG*NFU-1:0] older_flat;

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    frt_reg_stack #(.NFU(NFU), .DEPTH(DEPTH)) u_stack (
      .clk      (clk),
      .rst      (rst),
      .push_en  (iss_valid && (iss_reg == RW'(r))),
      .push_fu  (iss_fu),
      .pop_en   (ret_valid),
      .pop_fu   (ret_fu),
      .rb_en    (rb_valid),
      .rb_mask  (rb_mask),
      .top_fu   (cur_fu[r*NFU +: NFU]),
      .top_vld  (cur_vld[r]),
      .full     (full_vec[r]),
      .older_fu (older_flat[r*NFU +: NFU])
    );
  end

  frt_hold_or #(.NREG(NREG), .NFU(NFU)) u_hold (
    .older_flat (older_flat),
    .hold       (commit_block)
  );

  assign iss_ready = !full_vec[iss_reg];
endmodule

// File: rtl/frt_chk.sv
module frt_chk #(
  parameter int NREG = 8,
  parameter int NFU  = 4,
  parameter int RW   = 3
) (
  input logic                clk,
  input logic                rst,
  input logic                iss_valid,
  input logic [RW-1:0]       iss_reg,
  input logic [NFU-1:0]      iss_fu,
  input logic                iss_ready,
  input logic                ret_valid,
  input logic                rb_valid,
  input logic [NFU-1:0]      rb_mask,
  input logic [NREG*NFU-1:0] cur_fu,
  input logic [NREG-1:0]     cur_vld,
  input logic [NFU-1:0]      commit_block
);
  AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (cur_vld == '0 && commit_block == '0 && iss_ready)); // R1

  AST_ISSUE_TOP: assert property (@(posedge clk) disable iff (rst)
    (iss_valid && iss_ready && !rb_valid) |=>
      (cur_vld[$past(iss_reg)] && cur_fu[$past(iss_reg)*NFU +: NFU] == $past(iss_fu))); // R2

  AST_FULL_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (iss_valid && !iss_ready && !ret_valid && !rb_valid) |=>
      ($stable(cur_fu) && $stable(cur_vld) && $stable(commit_block))); // R5

  AST_RB_BLOCK_GONE: assert property (@(posedge clk) disable iff (rst)
    rb_valid |=> ((commit_block & $past(rb_mask)) == '0)); // R7

  for (genvar r = 0; r < NREG; r++) begin : g_r
    AST_ONEHOT_WRITER: assert property (@(posedge clk) disable iff (rst)
      cur_vld[r] ? ($countones(cur_fu[r*NFU +: NFU]) == 1)
                 : (cur_fu[r*NFU +: NFU] == '0)); // R3
    AST_RB_WRITER_GONE: assert property (@(posedge clk) disable iff (rst)
      rb_valid |=> ((cur_fu[r*NFU +: NFU] & $past(rb_mask)) == '0)); // R7
  end
endmodule

bind fu_result_table frt_chk #(.NREG(NREG), .NFU(NFU), .RW(RW)) u_chk (
  .clk(clk), .rst(rst), .iss_valid(iss_valid), .iss_reg(iss_reg), .iss_fu(iss_fu),
  .iss_ready(iss_ready), .ret_valid(ret_valid), .rb_valid(rb_valid), .rb_mask(rb_mask),
  .cur_fu(cur_fu), .cur_vld(cur_vld), .commit_block(commit_block)
);

// File: tb/fu_result_table_tb.sv
module fu_result_table_tb;
  localparam int NREG = 8, NFU = 4, DEPTH = 4, RW = 3;

  logic clk = 1'b0, rst = 1'b1;
  logic iss_valid = 0, ret_valid = 0, rb_valid = 0;
  logic [RW-1:0] iss_reg = '0;
  logic [NFU-1:0] iss_fu = '0, ret_fu = '0, rb_mask = '0;
  logic iss_ready;
  logic [NREG*NFU-1:0] cur_fu;
  logic [NREG-1:0] cur_vld;
  logic [NFU-1:0] commit_block;

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [NFU-1:0] m_ent [NREG][DEPTH];
  int m_cnt [NREG];
  logic [31:0] lfsr = 32'h1ace_b00c;

  always #4 clk = ~clk;

  fu_result_table #(.NREG(NREG), .NFU(NFU), .DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst(rst), .iss_valid(iss_valid), .iss_reg(iss_reg), .iss_fu(iss_fu),
    .iss_ready(iss_ready), .ret_valid(ret_valid), .ret_fu(ret_fu), .rb_valid(rb_valid),
    .rb_mask(rb_mask), .cur_fu(cur_fu), .cur_vld(cur_vld), .commit_block(commit_block)
  );

  function automatic logic [NFU-1:0] oh(int k);
    return NFU'(1) << k;
  endfunction

  task automatic chk(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int r = 0; r < NREG; r++) begin
      m_cnt[r] = 0;
      for (int i = 0; i < DEPTH; i++) m_ent[r][i] = '0;
    end
  endtask

  task automatic compare(string tag);
    logic [NFU-1:0] blk;
    blk = '0;
    for (int r = 0; r < NREG; r++) begin
      logic [NFU-1:0] ew;
      ew = (m_cnt[r] > 0) ? m_ent[r][m_cnt[r]-1] : '0;
      for (int i = 0; i < m_cnt[r] - 1; i++) blk = blk | m_ent[r][i];
      chk(cur_fu[r*NFU +: NFU] == ew && cur_vld[r] == (m_cnt[r] > 0), tag,
          $sformatf("reg%0d writer/valid", r),
          {cur_vld[r], cur_fu[r*NFU +: NFU]}, {(m_cnt[r] > 0), ew});
    end
    chk(commit_block == blk, tag, "commit_block", commit_block, blk);
  endtask

  // one clock: drive at negedge, update model, compare at next negedge
  task automatic cyc(bit iv, int ir, logic [NFU-1:0] ifu, bit dv, logic [NFU-1:0] dfu,
                     bit rv, logic [NFU-1:0] rm, string tag);
    bit ready;
    iss_valid = iv; iss_reg = RW'(ir); iss_fu = ifu;
    ret_valid = dv; ret_fu = dfu; rb_valid = rv; rb_mask = rm;
    #1;
    ready = (m_cnt[ir] < DEPTH);
    if (iv) chk(iss_ready == ready, "R5", "iss_ready", iss_ready, ready);
    @(posedge clk);
    if (rv) begin
      for (int r = 0; r < NREG; r++) begin
        int k;
        logic [NFU-1:0] t [DEPTH];
        k = 0;
        for (int i = 0; i < DEPTH; i++) t[i] = '0;
        for (int i = 0; i < m_cnt[r]; i++)
          if ((m_ent[r][i] & rm) == '0) begin t[k] = m_ent[r][i]; k++; end
        for (int i = 0; i < DEPTH; i++) m_ent[r][i] = t[i];
        m_cnt[r] = k;
      end
    end else begin
      if (dv)
        for (int r = 0; r < NREG; r++)
          if (m_cnt[r] > 0 && m_ent[r][0] == dfu) begin
            for (int i = 0; i < DEPTH - 1; i++) m_ent[r][i] = m_ent[r][i+1];
            m_ent[r][DEPTH-1] = '0;
            m_cnt[r]--;
          end
      if (iv && ready) begin
        m_ent[ir][m_cnt[ir]] = ifu;
        m_cnt[ir]++;
      end
    end
    @(negedge clk);
    iss_valid = 0; ret_valid = 0; rb_valid = 0;
    compare(tag);
  endtask

  task automatic do_reset();
    rst = 1;
    iss_valid = 0; ret_valid = 0; rb_valid = 0;
    repeat (2) @(negedge clk);
    rst = 0;
    model_clear();
  endtask

  task automatic fill();
    // reg r gets writers r%4, (r+1)%4, ... up to depth (r%4)+1
    for (int r = 0; r < NREG; r++)
      for (int d = 0; d <= r % DEPTH; d++)
        cyc(1, r, oh((r + d) % NFU), 0, '0, 0, '0, "R4");
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    model_clear();
    do_reset();
    #1;
    chk(cur_vld == '0 && cur_fu == '0, "R1", "empty after reset", {cur_vld, cur_fu}, '0);
    chk(commit_block == '0, "R1", "no block after reset", commit_block, '0);
    chk(iss_ready == 1'b1, "R1", "ready after reset", iss_ready, 1);
    @(negedge clk);

    // R2 R3: each register, each FU, single writer
    for (int r = 0; r < NREG; r++)
      for (int f = 0; f < NFU; f++) begin
        cyc(1, r, oh(f), 0, '0, 0, '0, "R2");
        cyc(0, 0, '0, 1, oh(f), 0, '0, "R6");
      end
    // R4 R5: fill register 5 and try one more
    for (int d = 0; d < DEPTH; d++) cyc(1, 5, oh(d), 0, '0, 0, '0, "R4");
    chk(commit_block == 4'b0111, "R4", "three superseded", commit_block, 4'b0111);
    cyc(1, 5, oh(0), 0, '0, 0, '0, "R5");
    // R6: retire a non-bottom unit (ignored), then bottom ones
    cyc(0, 0, '0, 1, oh(2), 0, '0, "R6");
    for (int d = 0; d < DEPTH; d++) cyc(0, 0, '0, 1, oh(d), 0, '0, "R6");
    chk(cur_vld == '0, "R6", "emptied", cur_vld, '0);
    // R9: full register, retire + issue same cycle: issue refused
    for (int d = 0; d < DEPTH; d++) cyc(1, 2, oh(d), 0, '0, 0, '0, "R4");
    cyc(1, 2, oh(3), 1, oh(0), 0, '0, "R9");
    cyc(1, 2, oh(0), 1, oh(1), 0, '0, "R9");
    // R8: rollback ignores issue and retire
    cyc(1, 6, oh(1), 1, oh(2), 1, 4'b0001, "R8");
    // R7: every rollback mask over a filled table
    for (int m = 0; m < (1 << NFU); m++) begin
      do_reset();
      fill();
      cyc(0, 0, '0, 0, '0, 1, NFU'(m), "R7");
    end
    // mixed traffic
    do_reset();
    for (int n = 0; n < 3000; n++) begin
      logic [NFU-1:0] dfu;
      int rr;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      rr = int'(lfsr[10:8]);
      dfu = (m_cnt[rr] > 0) ? m_ent[rr][0] : oh(int'(lfsr[12:11]));
      cyc(lfsr[0] | lfsr[1], int'(lfsr[4:2]), oh(int'(lfsr[6:5])),
          lfsr[7], dfu, (lfsr[15:13] == 3'd0), lfsr[19:16],
          (lfsr[15:13] == 3'd0) ? "R8" : "R9");
    end
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule